// File: doc/BRIEF.md
# Port VLAN Group Forwarding Filter

This block sits between the address lookup stage and the output queues of a small three-port layer 2 switch: two Ethernet ports (port 0 and port 1) and one port that leads to the on-chip processor (port 2). Each port is assigned to one of six port-membership groups. Each group lists which ports may exchange frames. For every frame, the lookup stage supplies the ingress port and a candidate destination mask. The filter trims that mask down to the members of the ingress port's group, and it never sends a frame back out of the port it came in on.

The filter also folds the frame's 3-bit priority into one of two traffic classes. A frame with no priority of its own takes the default priority of its ingress port. Group assignments, member sets and default priorities are set through a one-cycle write port. Requests enter through a valid/ready handshake, and the result is held in a single output register until the consumer takes it.

Top module: `vgf_filter`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every port belongs to group 0, group 0 contains all three ports, groups 1 to 5 are empty, and every default priority is 0.
- R2: For ingress port p (0..2), the result mask is `req_mask` AND the member set of p's group, with bit p cleared. Bit i of a mask stands for port i.
- R3: A write with `cfg_kind`=0 sets the group of port `cfg_idx` to `cfg_wdata[2:0]`.
- R4: A write with `cfg_kind`=1 sets the member set of group `cfg_idx` (0..5) to `cfg_wdata[2:0]`. Bit i set means port i is a member.
- R5: A port whose group value is 6 or 7 gets an empty result mask for every request.
- R6: The effective priority is `req_prio` when `req_has_prio` is 1. Otherwise it is the ingress port's default priority, or 0 for ingress port 3. `rsp_class` is 1 when the effective priority is 4..7 and 0 when it is 0..3.
- R7: A write with `cfg_kind`=2 sets the default priority of port `cfg_idx` to `cfg_wdata[2:0]`.
- R8: `req_ready` = NOT `rsp_valid` OR `rsp_ready`. An accepted request shows its result on `rsp_valid`/`rsp_mask`/`rsp_class` after the very next clock edge. While `rsp_valid` is 1 and `rsp_ready` is 0, the outputs hold still.
- R9: The following writes change no table: `cfg_kind`=3, `cfg_kind` 0 or 2 with `cfg_idx` of 3 or more, and `cfg_kind`=1 with `cfg_idx` of 6 or more.
- R10: Ingress port value 3 is not a port, and it always gets an empty result mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 2 | Table selector: 0 port group, 1 group members, 2 port default priority, 3 reserved |
| cfg_idx | input | 3 | Port or group number written |
| cfg_wdata | input | 3 | Value written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_port | input | 2 | Ingress port |
| req_mask | input | 3 | Candidate destination mask from lookup |
| req_has_prio | input | 1 | Frame carries its own priority |
| req_prio | input | 3 | Frame priority |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_mask | output | 3 | Filtered destination mask |
| rsp_class | output | 1 | Traffic class, 1 = high |

## Verification
The bench sweeps every ingress port, including the invalid value 3, together with every candidate mask, every priority and both priority sources. It does this under four table settings: the reset setting, a split into two overlapping groups, ports pointed at group values 6 and 7, and a burst of out-of-range writes. Each setting targets a different kind of fault. A design that forgets to clear the ingress bit echoes frames back to their sender. One that indexes past the sixth group picks up stale or unrelated members, where it should drop the frame. One that accepts an out-of-range write quietly rewrites a real port's group or priority, and the next sweep shows this as changed masks or classes. A stall test holds `rsp_ready` low while a second request is waiting. A register that overwrites its result while stalled, or that loses the waiting request when the stall ends, shows up as a wrong class in that test.

// File: rtl/vgf_pkg.sv
// Package vgf_pkg
// Purpose : shared default sizes and the table-selector encoding for the
//           port VLAN group forwarding filter.
// Assumes : nothing; constants only.
package vgf_pkg;

    localparam int DEF_NUM_PORTS  = 3;
    localparam int DEF_NUM_GROUPS = 6;
    localparam int DEF_GIDX_W     = 3;
    localparam int DEF_PRIO_W     = 3;

    typedef enum logic [1:0] {
        SEL_PORT_GROUP    = 2'd0,
        SEL_GROUP_MEMBERS = 2'd1,
        SEL_PORT_PRIO     = 2'd2,
        SEL_RESERVED      = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/vgf_cfg_regs.sv
// Module vgf_cfg_regs
// Purpose : holds the per-port group index, the per-group member sets and
//           the per-port default priority; updated by a one-cycle write.
// Assumes : writes with an out-of-range index or reserved selector are
//           discarded; tables are exported flat, entry k at [k*W +: W].
module vgf_cfg_regs
    import vgf_pkg::*;
#(
    parameter int NUM_PORTS  = DEF_NUM_PORTS,
    parameter int NUM_GROUPS = DEF_NUM_GROUPS,
    parameter int GIDX_W     = DEF_GIDX_W,
    parameter int PRIO_W     = DEF_PRIO_W,
    parameter int IDX_W      = 3,
    parameter int DATA_W     = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_kind,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [DATA_W-1:0]            cfg_wdata,
    output logic [NUM_PORTS*GIDX_W-1:0]  port_group,
    output logic [NUM_GROUPS*NUM_PORTS-1:0] group_members,
    output logic [NUM_PORTS*PRIO_W-1:0]  port_prio
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_kind);

    // One group register and one default-priority register for each port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Port group entry: reset to group 0, rewritten by a port-group write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_group[p*GIDX_W +: GIDX_W] <= '0;
            else if (cfg_we && sel == SEL_PORT_GROUP && cfg_idx == IDX_W'(p))
                port_group[p*GIDX_W +: GIDX_W] <= cfg_wdata[GIDX_W-1:0];
        end

        // Port default priority: reset to 0, rewritten by a priority write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_prio[p*PRIO_W +: PRIO_W] <= '0;
            else if (cfg_we && sel == SEL_PORT_PRIO && cfg_idx == IDX_W'(p))
                port_prio[p*PRIO_W +: PRIO_W] <= cfg_wdata[PRIO_W-1:0];
        end
    end

    // One member set for each group; only group 0 starts populated.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        localparam logic [NUM_PORTS-1:0] RST_SET = (g == 0) ? '1 : '0;
        // Group member set: reset per RST_SET, rewritten by a member write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                group_members[g*NUM_PORTS +: NUM_PORTS] <= RST_SET;
            else if (cfg_we && sel == SEL_GROUP_MEMBERS && cfg_idx == IDX_W'(g))
                group_members[g*NUM_PORTS +: NUM_PORTS] <= cfg_wdata[NUM_PORTS-1:0];
        end
    end

    // Out-of-range or reserved writes leave every table untouched (R9).
    assert_bad_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (sel == SEL_RESERVED
                    || (sel == SEL_GROUP_MEMBERS && cfg_idx >= IDX_W'(NUM_GROUPS))
                    || (sel != SEL_GROUP_MEMBERS && cfg_idx >= IDX_W'(NUM_PORTS))))
        |=> ($stable(port_group) && $stable(group_members) && $stable(port_prio)));

endmodule

// File: rtl/vgf_mask_calc.sv
// Module vgf_mask_calc
// Purpose : trims a candidate destination mask to the member set of the
//           ingress port's group and removes the ingress port itself.
// Assumes : an ingress number at or above NUM_PORTS, or a group index at or
//           above NUM_GROUPS, yields an empty mask. Purely combinational.
module vgf_mask_calc #(
    parameter int NUM_PORTS  = 3,
    parameter int NUM_GROUPS = 6,
    parameter int GIDX_W     = 3,
    parameter int PORT_W     = 2
) (
    input  logic [PORT_W-1:0]                req_port,
    input  logic [NUM_PORTS-1:0]             req_mask,
    input  logic [NUM_PORTS*GIDX_W-1:0]      port_group,
    input  logic [NUM_GROUPS*NUM_PORTS-1:0]  group_members,
    output logic [NUM_PORTS-1:0]             fwd_mask
);

    logic [GIDX_W-1:0]    sel_group;
    logic                 port_ok;
    logic [NUM_PORTS-1:0] members;
    logic [NUM_PORTS-1:0] ingress_bit;

    // Look up the ingress port's group and build its one-hot bit.
    always_comb begin
        sel_group   = '0;
        port_ok     = 1'b0;
        ingress_bit = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_port == PORT_W'(p)) begin
                sel_group      = port_group[p*GIDX_W +: GIDX_W];
                port_ok        = 1'b1;
                ingress_bit[p] = 1'b1;
            end
        end
    end

    // Select the group's member set; an unmatched index leaves it empty.
    always_comb begin
        members = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (sel_group == GIDX_W'(g))
                members = group_members[g*NUM_PORTS +: NUM_PORTS];
        end
    end

    // Combine candidate mask, member set and ingress exclusion.
    always_comb begin
        fwd_mask = port_ok ? (req_mask & members & ~ingress_bit) : '0;
    end

endmodule

// File: rtl/vgf_class_map.sv
// Module vgf_class_map
// Purpose : picks the effective frame priority (own or port default) and
//           folds it into a low or high traffic class.
// Assumes : the upper half of the priority range is the high class; an
//           ingress number outside the ports defaults to priority 0.
module vgf_class_map #(
    parameter int NUM_PORTS = 3,
    parameter int PRIO_W    = 3,
    parameter int PORT_W    = 2
) (
    input  logic [PORT_W-1:0]           req_port,
    input  logic                        req_has_prio,
    input  logic [PRIO_W-1:0]           req_prio,
    input  logic [NUM_PORTS*PRIO_W-1:0] port_prio,
    output logic                        traffic_class
);

    localparam logic [PRIO_W-1:0] HIGH_FROM = PRIO_W'(1) << (PRIO_W - 1);

    logic [PRIO_W-1:0] dflt_prio;
    logic [PRIO_W-1:0] eff_prio;

    // Fetch the ingress port's default priority.
    always_comb begin
        dflt_prio = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_port == PORT_W'(p))
                dflt_prio = port_prio[p*PRIO_W +: PRIO_W];
        end
    end

    // Choose the priority source and compare against the class split.
    always_comb begin
        eff_prio      = req_has_prio ? req_prio : dflt_prio;
        traffic_class = (eff_prio >= HIGH_FROM);
    end

endmodule

// File: rtl/vgf_filter.sv
// Module vgf_filter
// Purpose : top of the port VLAN group forwarding filter; accepts one
//           request per cycle through valid/ready and registers the trimmed
//           destination mask and traffic class one edge later.
// Assumes : a table write in the same cycle as an accepted request takes
//           effect for the following requests only.
module vgf_filter
    import vgf_pkg::*;
#(
    parameter int NUM_PORTS  = DEF_NUM_PORTS,
    parameter int NUM_GROUPS = DEF_NUM_GROUPS,
    parameter int GIDX_W     = DEF_GIDX_W,
    parameter int PRIO_W     = DEF_PRIO_W,
    localparam int PORT_W    = $clog2(NUM_PORTS + 1),
    localparam int IDX_W     = (PORT_W > GIDX_W) ? PORT_W : GIDX_W,
    localparam int DW_A      = (NUM_PORTS > GIDX_W) ? NUM_PORTS : GIDX_W,
    localparam int DATA_W    = (DW_A > PRIO_W) ? DW_A : PRIO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_kind,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PORT_W-1:0]    req_port,
    input  logic [NUM_PORTS-1:0] req_mask,
    input  logic                 req_has_prio,
    input  logic [PRIO_W-1:0]    req_prio,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [NUM_PORTS-1:0] rsp_mask,
    output logic                 rsp_class
);

    logic [NUM_PORTS*GIDX_W-1:0]     port_group;
    logic [NUM_GROUPS*NUM_PORTS-1:0] group_members;
    logic [NUM_PORTS*PRIO_W-1:0]     port_prio;
    logic [NUM_PORTS-1:0]            next_mask;
    logic                            next_class;
    logic                            accept;

    vgf_cfg_regs #(
        .NUM_PORTS(NUM_PORTS), .NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W),
        .PRIO_W(PRIO_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .port_group(port_group),
        .group_members(group_members), .port_prio(port_prio)
    );

    vgf_mask_calc #(
        .NUM_PORTS(NUM_PORTS), .NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W),
        .PORT_W(PORT_W)
    ) i_mask (
        .req_port(req_port), .req_mask(req_mask), .port_group(port_group),
        .group_members(group_members), .fwd_mask(next_mask)
    );

    vgf_class_map #(
        .NUM_PORTS(NUM_PORTS), .PRIO_W(PRIO_W), .PORT_W(PORT_W)
    ) i_class (
        .req_port(req_port), .req_has_prio(req_has_prio), .req_prio(req_prio),
        .port_prio(port_prio), .traffic_class(next_class)
    );

    // The output register is free when empty or being drained this cycle.
    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    // Output register: load on accept, clear valid when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_mask  <= '0;
            rsp_class <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_mask  <= next_mask;
            rsp_class <= next_class;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // An empty output register always takes a request (R8).
    assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    // A stalled result keeps its value (R8).
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask) && $stable(rsp_class)));

    // An accepted request is visible after the next edge (R8).
    assert_accept_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    // The result never names a port absent from the candidate mask (R2).
    assert_mask_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((rsp_mask & ~$past(req_mask)) == '0));

    // The ingress port never appears in its own result (R2).
    assert_no_ingress_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_port < PORT_W'(NUM_PORTS)) |=> (((rsp_mask >> $past(req_port)) & 1'b1) == '0));

    // A non-existent ingress port yields nothing (R10).
    assert_bad_port_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_port >= PORT_W'(NUM_PORTS)) |=> (rsp_mask == '0));

    // A port pointed at an unused group index yields nothing (R5).
    assert_bad_group_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_port < PORT_W'(NUM_PORTS)
         && port_group[int'(req_port)*GIDX_W +: GIDX_W] >= GIDX_W'(NUM_GROUPS))
        |=> (rsp_mask == '0));

    // A frame's own priority alone decides its class (R6).
    assert_own_prio_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_has_prio) |=> (rsp_class == $past(req_prio[PRIO_W-1])));

endmodule

// File: tb/test_vgf_filter.sv
module test_vgf_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_kind = '0;
    logic [2:0] cfg_idx = '0;
    logic [2:0] cfg_wdata = '0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_port = '0;
    logic [2:0] req_mask = '0;
    logic       req_has_prio = 1'b0;
    logic [2:0] req_prio = '0;
    logic       rsp_valid;
    logic       rsp_ready = 1'b1;
    logic [2:0] rsp_mask;
    logic       rsp_class;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench-side model of the tables, built from the requirements.
    int m_group[3];
    int m_members[6];
    int m_prio[3];

    always #10 clk = ~clk;

    vgf_filter i_vgf_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_port(req_port), .req_mask(req_mask),
        .req_has_prio(req_has_prio), .req_prio(req_prio), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_mask(rsp_mask), .rsp_class(rsp_class)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_mask(int p, int m);
        int g;
        if (p > 2) return 0;
        g = m_group[p];
        if (g > 5) return 0;
        return m & m_members[g] & ~(1 << p) & 7;
    endfunction

    function automatic int exp_class(int p, int has, int pr);
        int e;
        e = has ? pr : ((p > 2) ? 0 : m_prio[p]);
        return (e >= 4) ? 1 : 0;
    endfunction

    task automatic cfg_write(int kind, int idx, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_idx = 3'(idx); cfg_wdata = 3'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind == 0 && idx < 3) m_group[idx] = data;
        if (kind == 1 && idx < 6) m_members[idx] = data;
        if (kind == 2 && idx < 3) m_prio[idx] = data;
    endtask

    // Full sweep of ports, masks, priority source and priority.
    task automatic sweep(string tag_mask, string tag_cls);
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 8; m++)
                for (int h = 0; h < 2; h++)
                    for (int pr = 0; pr < 8; pr++) begin
                        @(negedge clk);
                        req_valid = 1'b1; req_port = 2'(p); req_mask = 3'(m);
                        req_has_prio = h[0]; req_prio = 3'(pr);
                        @(negedge clk);
                        req_valid = 1'b0;
                        if (!rsp_valid) chk({tag_mask, " valid"}, 0, 1);
                        chk({tag_mask, " mask"}, int'(rsp_mask), exp_mask(p, m));
                        chk({tag_cls, " class"}, int'(rsp_class), exp_class(p, h, pr));
                    end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 3; i++) begin m_group[i] = 0; m_prio[i] = 0; end
        for (int g = 0; g < 6; g++) m_members[g] = (g == 0) ? 7 : 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the handshake
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        sweep("R1/R2/R10", "R1/R6");

        // R3, R4, R7: two overlapping groups and distinct default priorities
        cfg_write(0, 0, 1); cfg_write(0, 1, 2); cfg_write(0, 2, 1);
        cfg_write(1, 1, 5); cfg_write(1, 2, 6);
        cfg_write(2, 0, 5); cfg_write(2, 1, 2); cfg_write(2, 2, 7);
        sweep("R2/R3/R4", "R6/R7");

        // R5: ports pointed at unused group values
        cfg_write(0, 1, 6); cfg_write(0, 2, 7);
        sweep("R5", "R6");

        // R9: writes that must change nothing
        cfg_write(0, 3, 0); cfg_write(1, 6, 7); cfg_write(1, 7, 7);
        cfg_write(2, 3, 6); cfg_write(2, 4, 6); cfg_write(3, 0, 7); cfg_write(3, 1, 0);
        cfg_write(0, 5, 0);
        sweep("R9", "R9");

        // R8: stall with a second request waiting
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_port = 2'd0; req_mask = 3'd7; req_has_prio = 1'b1; req_prio = 3'd6;
        @(negedge clk);
        chk("R8 valid after accept", int'(rsp_valid), 1);
        chk("R8 ready while stalled", int'(req_ready), 0);
        chk("R8 first mask", int'(rsp_mask), 4);
        req_mask = 3'd5; req_prio = 3'd2;
        repeat (2) begin
            @(negedge clk);
            chk("R8 held mask", int'(rsp_mask), 4);
            chk("R8 held class", int'(rsp_class), 1);
            chk("R8 held valid", int'(rsp_valid), 1);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 second valid", int'(rsp_valid), 1);
        chk("R8 second class", int'(rsp_class), 0);
        chk("R8 second mask", int'(rsp_mask), 4);
        @(negedge clk);
        chk("R8 drained", int'(rsp_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule